// File: doc/BRIEF.md
# DMA command, status and interrupt unit

This block is the control-and-status front end of a single-channel byte DMA engine. Software talks to it over a small byte-wide register port. It can write mode bytes, a block length, a compare byte, a compare mask and an interrupt vector base. It can also issue one-byte immediate commands and read back a status byte and the running byte count. The block holds the engine-enable bit, and the transfer sequencers elsewhere use that bit to decide whether to run.

The transfer datapath hands each byte it has read to this block with a one-cycle `byteValid` strobe. The block counts the byte. It compares the byte against the programmed pattern, ignoring the bit positions that the mask marks as don't-care. It flags end-of-block on the last byte. The programmed length is the block size minus one. Interrupt requests are raised on the causes software enabled, and the block presents a vector whose two low bits can name the cause. The `addrLoad` pulse tells the address sequencer to reload its starting addresses.

Top module: `dma_cs_unit`

## Requirements
- R1: Any write on the register port disables the engine (`engineEn` low from the next cycle). The only exceptions are the enable command (code 0x01) and the continue command (code 0x05), which set `engineEn` from the next cycle.
- R2: The read-status command (0x08) and the start-read-sequence command (0x09) also leave the engine disabled.
- R3: The length registers hold N-1 for an N-byte block. The low byte is at address 2 and the high byte at address 3. A stored value of 0 is treated as 1, so the smallest block is 2 bytes. On the byte accepted while the count equals that length, `blockEnd` is high in the same cycle. On the next edge the count returns to 0, the end-of-block flag sets and the engine is disabled.
- R4: A write to address 0 is an immediate command. The codes are 0x01 enable, 0x02 disable, 0x03 reset, 0x04 load starting addresses, 0x05 continue, 0x06 clear count and 0x07 clear status. Reset clears the mode register, the count, both flags and the enable bit. Continue clears the count and enables. Load gives `addrLoad` high combinationally for that write cycle.
- R5: Reading address 0 returns the status byte. Bit 0 is the `readyIn` level, bit 1 the end-of-block flag, bit 2 the match flag, bit 3 the interrupt request and bit 4 the enable bit. Bits 7:5 are zero.
- R6: Reading address 1 returns the count's low byte and reading address 2 returns its high byte. Any other read address returns 0.
- R7: An accepted byte matches when it equals the compare byte (address 4) in every bit position where the mask byte (address 5) holds 0. A match sets the match flag from the next cycle.
- R8: Mode register (address 1) bits select the interrupt causes: bit 0 for ready, bit 1 for match, bit 2 for end of block. `irqOut` is high while any selected cause is present. The ready cause is `readyIn` high while the engine is enabled.
- R9: When mode bit 3 is set, `irqVector` is the vector base (address 6) with bits 1:0 replaced by the cause code: 10 for end of block, 01 for match, 00 for ready, taken in that priority. When mode bit 3 is clear, `irqVector` is the base unchanged.
- R10: The clear-status command clears the end-of-block and match flags. The interrupt then drops unless another selected cause is still present.
- R11: An accepted byte is always fully processed (counted, compared and terminal-checked), whatever the enable bit, `readyIn` or a command in the same cycle. A clear-count in that cycle restarts the count from the byte. A clear-status in that cycle loses to the flag the byte sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWrEn | input | 1 | Register write strobe |
| cpuAddr | input | 3 | Register address for writes and reads |
| cpuWrData | input | 8 | Write data or command code |
| cpuRdData | output | 8 | Read data selected by `cpuAddr` |
| readyIn | input | 1 | Port ready level |
| byteValid | input | 1 | A byte has been read by the datapath |
| byteData | input | 8 | The byte that was read |
| engineEn | output | 1 | Engine enable |
| addrLoad | output | 1 | Reload starting addresses |
| blockEnd | output | 1 | Current byte ends the block |
| irqOut | output | 1 | Interrupt request |
| irqVector | output | 8 | Interrupt vector |

## Verification
A byte completion and a register command can fall in the same cycle. This is the case that matters most: a disable or clear-count against a byte being counted, a clear-status against a byte that matches or ends the block, or an enable against a terminal byte. Directed steps line these pairs up on purpose, and a seeded random phase keeps provoking them with short lengths and random masks. Each cycle the outputs are judged against a bench-side model of the requirements. The rules applied are: the byte's own effect survives, and an enable command outranks the terminal disable.

// File: rtl/dma_cs_pkg.sv
package dma_cs_pkg;
  localparam int DATA_W    = 8;
  localparam int CNT_W     = 16;
  localparam int ADDR_W    = 3;
  localparam int LEN_BYTES = CNT_W / DATA_W;

  localparam logic [ADDR_W-1:0] ADDR_CMD    = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MODE   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_LEN0   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_MATCH  = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_MASK   = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_VEC    = 3'd6;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT0   = 3'd1;

  typedef enum logic [DATA_W-1:0] {
    CMD_ENABLE   = 8'h01,
    CMD_DISABLE  = 8'h02,
    CMD_RESET    = 8'h03,
    CMD_LOAD     = 8'h04,
    CMD_CONTINUE = 8'h05,
    CMD_CLRCNT   = 8'h06,
    CMD_CLRSTAT  = 8'h07,
    CMD_RDSTAT   = 8'h08,
    CMD_RDSEQ    = 8'h09
  } cmd_e;

  typedef struct packed {
    logic vecHasCause;
    logic irqEob;
    logic irqMatch;
    logic irqReady;
  } mode_t;

  typedef struct packed {
    logic clrCount;
    logic clrStatus;
  } strobe_t;
endpackage

// File: rtl/dma_cs_ctrl.sv
module dma_cs_ctrl
  import dma_cs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWrEn,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              termHit,
  output logic              engineEn,
  output logic              addrLoad,
  output strobe_t           strobes,
  output mode_t             mode,
  output logic [CNT_W-1:0]  lenVal,
  output logic [DATA_W-1:0] matchByte,
  output logic [DATA_W-1:0] maskByte,
  output logic [DATA_W-1:0] vecBase
);
  cmd_e cmd;
  logic isCmd, enCmd, rstCmd, haltCmd;
  logic [CNT_W-1:0] lenReg;

  assign cmd     = cmd_e'(cpuWrData);
  assign isCmd   = cpuWrEn && (cpuAddr == ADDR_CMD);
  assign enCmd   = isCmd && (cmd == CMD_ENABLE || cmd == CMD_CONTINUE);
  assign rstCmd  = isCmd && (cmd == CMD_RESET);
  assign haltCmd = isCmd && (cmd == CMD_RDSTAT || cmd == CMD_RDSEQ);

  assign strobes.clrCount  = isCmd && (cmd == CMD_CLRCNT || cmd == CMD_CONTINUE || cmd == CMD_RESET);
  assign strobes.clrStatus = isCmd && (cmd == CMD_CLRSTAT || cmd == CMD_RESET);
  assign addrLoad          = isCmd && (cmd == CMD_LOAD);

  always_ff @(posedge clk) begin
    if (!rstN)                   engineEn <= 1'b0;
    else if (enCmd)              engineEn <= 1'b1;
    else if (cpuWrEn || termHit) engineEn <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN || rstCmd)                          mode <= '0;
    else if (cpuWrEn && cpuAddr == ADDR_MODE)     mode <= mode_t'(cpuWrData[3:0]);
  end

  for (genvar i = 0; i < LEN_BYTES; i++) begin : g_len
    always_ff @(posedge clk) begin
      if (!rstN) lenReg[i*DATA_W +: DATA_W] <= '0;
      else if (cpuWrEn && cpuAddr == ADDR_W'(ADDR_LEN0 + i))
        lenReg[i*DATA_W +: DATA_W] <= cpuWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchByte <= '0;
      maskByte  <= '0;
      vecBase   <= '0;
    end else if (cpuWrEn) begin
      if (cpuAddr == ADDR_MATCH) matchByte <= cpuWrData;
      if (cpuAddr == ADDR_MASK)  maskByte  <= cpuWrData;
      if (cpuAddr == ADDR_VEC)   vecBase   <= cpuWrData;
    end
  end

  assign lenVal = (lenReg == '0) ? CNT_W'(1) : lenReg;

  p_write_disables_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrEn && !enCmd) |=> !engineEn);
  p_halt_cmds_r2: assert property (@(posedge clk) disable iff (!rstN)
    haltCmd |=> !engineEn);
  p_enable_cmd_r4: assert property (@(posedge clk) disable iff (!rstN)
    enCmd |=> engineEn);
  p_term_disables_r3: assert property (@(posedge clk) disable iff (!rstN)
    (termHit && !enCmd) |=> !engineEn);
endmodule

// File: rtl/dma_cs_dp.sv
module dma_cs_dp
  import dma_cs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  mode_t             mode,
  input  logic [CNT_W-1:0]  lenVal,
  input  logic [DATA_W-1:0] matchByte,
  input  logic [DATA_W-1:0] maskByte,
  input  logic [DATA_W-1:0] vecBase,
  input  logic              engineEn,
  input  logic              readyIn,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              termHit,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              irqOut,
  output logic [DATA_W-1:0] irqVector
);
  logic [CNT_W-1:0] count, base;
  logic eobFlag, matchFlag, hit;
  logic causeEob, causeMatch, causeReady;
  logic [1:0] causeCode;
  logic [DATA_W-1:0] statusByte;

  assign base    = strobes.clrCount ? '0 : count;
  assign termHit = byteValid && (base == lenVal);
  assign hit     = byteValid && (((byteData ^ matchByte) & ~maskByte) == '0);

  always_ff @(posedge clk) begin
    if (!rstN)          count <= '0;
    else if (termHit)   count <= '0;
    else if (byteValid) count <= base + CNT_W'(1);
    else                count <= base;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eobFlag   <= 1'b0;
      matchFlag <= 1'b0;
    end else begin
      eobFlag   <= termHit | (eobFlag   & ~strobes.clrStatus);
      matchFlag <= hit     | (matchFlag & ~strobes.clrStatus);
    end
  end

  assign causeEob   = mode.irqEob   && eobFlag;
  assign causeMatch = mode.irqMatch && matchFlag;
  assign causeReady = mode.irqReady && engineEn && readyIn;
  assign irqOut     = causeEob || causeMatch || causeReady;

  always_comb begin
    if (causeEob)        causeCode = 2'b10;
    else if (causeMatch) causeCode = 2'b01;
    else                 causeCode = 2'b00;
  end

  assign irqVector = mode.vecHasCause ? {vecBase[DATA_W-1:2], causeCode} : vecBase;

  assign statusByte = {3'b000, engineEn, irqOut, matchFlag, eobFlag, readyIn};

  always_comb begin
    cpuRdData = '0;
    if (cpuAddr == ADDR_STATUS) cpuRdData = statusByte;
    for (int i = 0; i < LEN_BYTES; i++)
      if (cpuAddr == ADDR_W'(ADDR_CNT0 + i)) cpuRdData = count[i*DATA_W +: DATA_W];
  end

  p_count_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    termHit |=> (count == '0) && eobFlag);
  p_match_sets_r7: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> matchFlag);
  p_clear_status_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrStatus && !termHit && !hit) |=> !eobFlag && !matchFlag);
  p_byte_counted_r11: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !termHit && !strobes.clrCount) |=> count == $past(count) + CNT_W'(1));
  p_ready_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    (mode.irqReady && engineEn && readyIn) |-> irqOut);
endmodule

// File: rtl/dma_cs_unit.sv
module dma_cs_unit
  import dma_cs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWrEn,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic [DATA_W-1:0] cpuRdData,
  input  logic              readyIn,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  output logic              engineEn,
  output logic              addrLoad,
  output logic              blockEnd,
  output logic              irqOut,
  output logic [DATA_W-1:0] irqVector
);
  strobe_t           strobes;
  mode_t             mode;
  logic [CNT_W-1:0]  lenVal;
  logic [DATA_W-1:0] matchByte, maskByte, vecBase;
  logic              termHit;

  dma_cs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .termHit(termHit), .engineEn(engineEn), .addrLoad(addrLoad), .strobes(strobes),
    .mode(mode), .lenVal(lenVal), .matchByte(matchByte), .maskByte(maskByte), .vecBase(vecBase)
  );

  dma_cs_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .mode(mode), .lenVal(lenVal),
    .matchByte(matchByte), .maskByte(maskByte), .vecBase(vecBase), .engineEn(engineEn),
    .readyIn(readyIn), .byteValid(byteValid), .byteData(byteData), .cpuAddr(cpuAddr),
    .termHit(termHit), .cpuRdData(cpuRdData), .irqOut(irqOut), .irqVector(irqVector)
  );

  assign blockEnd = termHit;
endmodule

// File: tb/dma_cs_unit_test.sv
module dma_cs_unit_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, cpuWrEn, readyIn, byteValid;
  logic [2:0] cpuAddr;
  logic [7:0] cpuWrData, byteData, cpuRdData, irqVector;
  logic engineEn, addrLoad, blockEnd, irqOut;

  dma_cs_unit uut (
    .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuRdData(cpuRdData), .readyIn(readyIn), .byteValid(byteValid), .byteData(byteData),
    .engineEn(engineEn), .addrLoad(addrLoad), .blockEnd(blockEnd), .irqOut(irqOut),
    .irqVector(irqVector)
  );

  int nChecks = 0, nFail = 0;

  // bench-side model state, derived from the requirements
  logic mEn, mEob, mMf;
  logic [3:0] mMode;
  logic [7:0] mMatch, mMask, mVec;
  logic [15:0] mLen, mCount;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic expIrq(input logic rdy);
    return (mMode[0] && mEn && rdy) || (mMode[1] && mMf) || (mMode[2] && mEob);
  endfunction

  function automatic logic [7:0] expVec();
    logic [1:0] code;
    code = (mMode[2] && mEob) ? 2'b10 : (mMode[1] && mMf) ? 2'b01 : 2'b00;
    return mMode[3] ? {mVec[7:2], code} : mVec;
  endfunction

  function automatic logic [7:0] expRead(input logic [2:0] a, input logic rdy);
    case (a)
      3'd0: return {3'b000, mEn, expIrq(rdy), mMf, mEob, rdy};
      3'd1: return mCount[7:0];
      3'd2: return mCount[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic step(input logic w, input logic [2:0] a, input logic [7:0] d,
                      input logic rdy, input logic bv, input logic [7:0] bd);
    logic isCmd, clrC, clrS, rst, enC, term, hit;
    logic [15:0] base, eff;
    @(negedge clk);
    cpuWrEn = w; cpuAddr = a; cpuWrData = d; readyIn = rdy; byteValid = bv; byteData = bd;
    isCmd = w && (a == 3'd0);
    rst   = isCmd && d == 8'h03;
    enC   = isCmd && (d == 8'h01 || d == 8'h05);
    clrC  = isCmd && (d == 8'h06 || d == 8'h05 || d == 8'h03);
    clrS  = isCmd && (d == 8'h07 || d == 8'h03);
    eff   = (mLen == 16'd0) ? 16'd1 : mLen;
    base  = clrC ? 16'd0 : mCount;
    term  = bv && (base == eff);
    hit   = bv && (((bd ^ mMatch) & ~mMask) == 8'h00);
    #2;
    chk("R1", engineEn, mEn);
    chk("R3", blockEnd, term);
    chk("R4", addrLoad, isCmd && d == 8'h04);
    chk(a == 3'd0 ? "R5" : "R6", cpuRdData, expRead(a, rdy));
    chk("R8", irqOut, expIrq(rdy));
    chk("R9", irqVector, expVec());
    @(posedge clk);
    mCount = term ? 16'd0 : (bv ? base + 16'd1 : base);
    mEob   = term | (mEob & ~clrS);
    mMf    = hit  | (mMf  & ~clrS);
    mEn    = enC ? 1'b1 : ((w || term) ? 1'b0 : mEn);
    if (rst) mMode = 4'h0;
    else if (w && a == 3'd1) mMode = d[3:0];
    if (w && a == 3'd2) mLen[7:0]  = d;
    if (w && a == 3'd3) mLen[15:8] = d;
    if (w && a == 3'd4) mMatch = d;
    if (w && a == 3'd5) mMask  = d;
    if (w && a == 3'd6) mVec   = d;
  endtask

  task automatic idle(input logic [2:0] a);
    step(1'b0, a, 8'h00, 1'b0, 1'b0, 8'h00);
  endtask

  initial begin
    #(8 * 200000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; cpuWrEn = 0; cpuAddr = 0; cpuWrData = 0; readyIn = 0; byteValid = 0; byteData = 0;
    mEn = 0; mEob = 0; mMf = 0; mMode = 0; mMatch = 0; mMask = 0; mVec = 0; mLen = 0; mCount = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // reset state
    #2;
    chk("R5", cpuRdData, 8'h00);
    chk("R1", engineEn, 1'b0);
    chk("R8", irqOut, 1'b0);

    // R3 / R7 / R9: five-byte block (length 4), match on byte four
    step(1, 3'd2, 8'h04, 0, 0, 0);
    step(1, 3'd3, 8'h00, 0, 0, 0);
    step(1, 3'd1, 8'h0E, 0, 0, 0);
    step(1, 3'd4, 8'h5A, 0, 0, 0);
    step(1, 3'd5, 8'h0F, 0, 0, 0);
    step(1, 3'd6, 8'hA0, 0, 0, 0);
    step(1, 3'd0, 8'h01, 0, 0, 0);
    #1 chk("R4", engineEn, 1'b1);
    for (int i = 0; i < 3; i++) step(0, 3'd1, 0, 0, 1, 8'h11);
    #1 chk("R7", cpuRdData, 8'h03);
    step(0, 3'd0, 0, 0, 1, 8'h53);
    #1 chk("R7", cpuRdData[2], 1'b1);
    chk("R9", irqVector, 8'hA1);
    step(0, 3'd0, 0, 0, 1, 8'h22);
    #1 chk("R3", engineEn, 1'b0);
    chk("R3", cpuRdData[1], 1'b1);
    chk("R9", irqVector, 8'hA2);
    idle(3'd1);
    #1 chk("R3", cpuRdData, 8'h00);

    // R10: clear status drops the interrupt
    step(1, 3'd0, 8'h07, 0, 0, 0);
    #1 chk("R10", irqOut, 1'b0);
    chk("R10", cpuRdData[2:1], 2'b00);

    // R2: read-status and start-read-sequence commands halt
    step(1, 3'd0, 8'h01, 0, 0, 0);
    step(1, 3'd0, 8'h08, 0, 0, 0);
    #1 chk("R2", engineEn, 1'b0);
    step(1, 3'd0, 8'h01, 0, 0, 0);
    step(1, 3'd0, 8'h09, 0, 0, 0);
    #1 chk("R2", engineEn, 1'b0);

    // R1: plain register write halts
    step(1, 3'd0, 8'h01, 0, 0, 0);
    step(1, 3'd5, 8'hFF, 0, 0, 0);
    #1 chk("R1", engineEn, 1'b0);

    // R11: clear-status vs matching byte, disable vs counted byte
    step(1, 3'd0, 8'h07, 0, 1, 8'h00);
    #1 chk("R11", cpuRdData[2], 1'b1);
    step(1, 3'd0, 8'h02, 1, 1, 8'h00);
    idle(3'd1);
    #1 chk("R11", cpuRdData, 8'h02);
    step(1, 3'd0, 8'h06, 0, 1, 8'h00);
    idle(3'd1);
    #1 chk("R11", cpuRdData, 8'h01);

    // R8: ready cause
    step(1, 3'd1, 8'h01, 0, 0, 0);
    step(1, 3'd0, 8'h07, 0, 0, 0);
    step(1, 3'd0, 8'h01, 0, 0, 0);
    step(0, 3'd0, 0, 1, 0, 0);
    #1 chk("R8", irqOut, 1'b1);

    // R6: long block, count high byte, length 0x100
    step(1, 3'd2, 8'h00, 0, 0, 0);
    step(1, 3'd3, 8'h01, 0, 0, 0);
    step(1, 3'd0, 8'h05, 0, 0, 0);
    for (int i = 0; i < 257; i++) step(0, 3'd2, 0, 0, 1, 8'h77);
    #1 chk("R6", cpuRdData, 8'h00);

    // R3: stored length 0 behaves as 1
    step(1, 3'd2, 8'h00, 0, 0, 0);
    step(1, 3'd3, 8'h00, 0, 0, 0);
    step(1, 3'd0, 8'h05, 0, 0, 0);
    step(0, 3'd1, 0, 0, 1, 8'h00);
    #1 chk("R3", cpuRdData, 8'h01);
    step(0, 3'd1, 0, 0, 1, 8'h00);
    #1 chk("R3", cpuRdData, 8'h00);

    // constrained random phase
    for (int i = 0; i < 1500; i++) begin
      logic w, rdy, bv;
      logic [2:0] a;
      logic [7:0] d;
      w   = ($urandom % 5) == 0;
      a   = w ? 3'($urandom % 7) : 3'($urandom % 4);
      if (a == 3'd0)      d = 8'($urandom % 10);
      else if (a == 3'd2) d = 8'($urandom % 6);
      else if (a == 3'd3) d = 8'h00;
      else                d = 8'($urandom);
      rdy = 1'($urandom);
      bv  = 1'($urandom);
      step(w, a, d, rdy, bv, 8'($urandom));
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule